// File: doc/BRIEF.md
# Bridge Master-Abort Response Handler

A bus bridge forwards a transaction onto one of its two sides. Sometimes no target claims that transaction, and it ends in a master abort. This block decides how the bridge then answers the agent that started the cycle.

Each completing transaction arrives as a one-cycle completion strobe. The strobe comes with an abort flag, the direction, the side that was being mastered, a flag saying whether the originating cycle can still be target-aborted, and any read data. The block produces a registered response one cycle later: the read data, a write-discard strobe, a target-abort request, and an active-low system-error pulse.

A control register holds the policy. When the report-mode bit is clear, aborts are absorbed quietly: reads return all ones and write data is dropped. When the report-mode bit is set, the abort is reported as a target abort if that is still possible. Otherwise it is reported as a one-clock system-error pulse, but only when system-error reporting is enabled. A sticky received-abort status bit for each side records every abort, and software clears it by writing 1.

Top module: `bridge_abort_resp`

## Requirements
- R1: After reset the report-mode bit `cfg_mode`, the error-enable bit `cfg_serr_en` and all `sts_rma` bits are 0, `serr_n` is 1, and `rsp_valid` is 0.
- R2: A completion strobe sampled at a clock edge yields `rsp_valid` for exactly the cycle after that edge. A non-aborted read returns `xfer_rdata` unchanged. A non-aborted write gives `rsp_wr_discard` 0. Neither raises `rsp_tgt_abort` or pulls `serr_n` low.
- R3: With `cfg_mode`=0, an aborted transaction raises neither `rsp_tgt_abort` nor a low `serr_n`. An aborted read returns 32'hFFFF_FFFF.
- R4: Every aborted write, in either mode, gives `rsp_wr_discard`=1 in its response cycle.
- R5: With `cfg_mode`=1 and `xfer_ta_ok`=1, an aborted transaction gives `rsp_tgt_abort`=1 and `serr_n` stays 1.
- R6: With `cfg_mode`=1, `xfer_ta_ok`=0 and `cfg_serr_en`=1, an aborted transaction drives `serr_n` low for exactly the response cycle, with no target abort.
- R7: With `cfg_mode`=1, `xfer_ta_ok`=0 and `cfg_serr_en`=0, an aborted transaction raises neither a target abort nor a system-error pulse.
- R8: The response does not depend on `xfer_side` (0 = primary, 1 = secondary).
- R9: `sts_rma[s]` is set by every abort on side s, whatever the mode. It holds until a control write with `cfg_wdata[2+s]`=1. If a set and a clear fall on the same edge, the set wins.
- R10: A control write (`cfg_wdata[0]` = report mode, `cfg_wdata[1]` = error enable) takes effect at its edge. A transaction sampled on that same edge still uses the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_valid | input | 1 | Completion strobe, one cycle per transaction |
| xfer_mabort | input | 1 | Transaction ended in master abort |
| xfer_is_read | input | 1 | 1 = read, 0 = write |
| xfer_side | input | 1 | Side mastered: 0 primary, 1 secondary |
| xfer_ta_ok | input | 1 | Originating cycle can still be target-aborted |
| xfer_rdata | input | 32 | Read data from the target side |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 4 | [0] report mode, [1] error enable, [3:2] write-1-clear status |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 32 | Read data to the requester |
| rsp_wr_discard | output | 1 | Write data dropped |
| rsp_tgt_abort | output | 1 | Request target-abort termination |
| serr_n | output | 1 | System-error pulse, active low |
| cfg_mode | output | 1 | Current report-mode bit |
| cfg_serr_en | output | 1 | Current error-enable bit |
| sts_rma | output | 2 | Sticky received-master-abort flags per side |

## Verification
Each response output, including `serr_n`, is due in the single cycle after the edge that samples its completion strobe. The control and status outputs change at the edge of the write or abort that moves them. The driver applies a stimulus at a falling edge and queues what it expects. The monitor compares at every later falling edge, when the registered outputs have settled. On cycles with no queued item it checks that the responses are idle, which also confirms that the error pulse has ended. Status and control bits are read at the falling edge after the edge that changes them.

// File: rtl/brab_pkg.sv
package brab_pkg;
  typedef struct packed {
    logic force_ones;
    logic discard;
    logic tgt_abort;
    logic serr;
  } brab_act_t;
endpackage

// File: rtl/brab_ctl.sv
module brab_ctl #(
  parameter int SIDES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_mode,
  input  logic             wr_serr_en,
  input  logic [SIDES-1:0] clr_mask,
  input  logic [SIDES-1:0] set_mask,
  output logic             mode_q,
  output logic             serr_en_q,
  output logic [SIDES-1:0] sts_q
);
  logic mode_d, serr_en_d;

  always_comb begin
    mode_d    = mode_q;
    serr_en_d = serr_en_q;
    if (wr_en) begin
      mode_d    = wr_mode;
      serr_en_d = wr_serr_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      serr_en_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      serr_en_q <= serr_en_d;
    end
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_sts
    logic sts_d;
    always_comb begin
      sts_d = sts_q[s];
      if (clr_mask[s]) sts_d = 1'b0;
      if (set_mask[s]) sts_d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q[s] <= 1'b0;
      else        sts_q[s] <= sts_d;
    end

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[s] && !clr_mask[s]) |=> sts_q[s]);
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set_mask[s] |=> sts_q[s]);
  end
endmodule

// File: rtl/brab_policy.sv
module brab_policy
  import brab_pkg::*;
(
  input  logic      in_valid,
  input  logic      in_abort,
  input  logic      in_is_read,
  input  logic      in_ta_ok,
  input  logic      mode,
  input  logic      serr_en,
  output brab_act_t act
);
  logic hit, report;

  always_comb begin
    hit            = in_valid && in_abort;
    report         = hit && mode;
    act.force_ones = hit && in_is_read;
    act.discard    = hit && !in_is_read;
    act.tgt_abort  = report && in_ta_ok;
    act.serr       = report && !in_ta_ok && serr_en;
  end
endmodule

// File: rtl/brab_resp.sv
module brab_resp
  import brab_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_abort,
  input  logic          in_is_read,
  input  logic [DW-1:0] in_rdata,
  input  logic          mode,
  input  brab_act_t     act,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_discard,
  output logic          rsp_ta,
  output logic          serr_n
);
  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  logic          valid_d, discard_d, ta_d, serr_n_d;
  logic [DW-1:0] rdata_d;

  always_comb begin
    valid_d   = in_valid;
    rdata_d   = '0;
    if (in_valid && in_is_read) rdata_d = act.force_ones ? ONES : in_rdata;
    discard_d = act.discard;
    ta_d      = act.tgt_abort;
    serr_n_d  = !act.serr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_discard <= 1'b0;
      rsp_ta      <= 1'b0;
      serr_n      <= 1'b1;
    end else begin
      rsp_valid   <= valid_d;
      rsp_rdata   <= rdata_d;
      rsp_discard <= discard_d;
      rsp_ta      <= ta_d;
      serr_n      <= serr_n_d;
    end
  end

  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_abort && !mode) |=> (serr_n && !rsp_ta));
  p_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_abort && in_is_read) |=> (rsp_rdata == ONES));
  p_ta_no_serr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ta |-> serr_n);
  p_serr_needs_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |-> rsp_valid);
  p_discard_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_abort && !in_is_read) |=> rsp_discard);
endmodule

// File: rtl/bridge_abort_resp.sv
module bridge_abort_resp
  import brab_pkg::*;
#(
  parameter int DW    = 32,
  parameter int SIDES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer_valid,
  input  logic               xfer_mabort,
  input  logic               xfer_is_read,
  input  logic               xfer_side,
  input  logic               xfer_ta_ok,
  input  logic [DW-1:0]      xfer_rdata,
  input  logic               cfg_we,
  input  logic [SIDES+1:0]   cfg_wdata,
  output logic               rsp_valid,
  output logic [DW-1:0]      rsp_rdata,
  output logic               rsp_wr_discard,
  output logic               rsp_tgt_abort,
  output logic               serr_n,
  output logic               cfg_mode,
  output logic               cfg_serr_en,
  output logic [SIDES-1:0]   sts_rma
);
  localparam int SW = (SIDES > 1) ? $clog2(SIDES) : 1;

  logic [SIDES-1:0] set_mask, clr_mask;
  logic [SW-1:0]    side_idx;
  brab_act_t        act;

  assign side_idx = SW'(xfer_side);

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    assign set_mask[s] = xfer_valid && xfer_mabort && (side_idx == SW'(s));
    assign clr_mask[s] = cfg_we && cfg_wdata[2+s];
  end

  brab_ctl #(.SIDES(SIDES)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_we),
    .wr_mode    (cfg_wdata[0]),
    .wr_serr_en (cfg_wdata[1]),
    .clr_mask   (clr_mask),
    .set_mask   (set_mask),
    .mode_q     (cfg_mode),
    .serr_en_q  (cfg_serr_en),
    .sts_q      (sts_rma)
  );

  brab_policy u_pol (
    .in_valid   (xfer_valid),
    .in_abort   (xfer_mabort),
    .in_is_read (xfer_is_read),
    .in_ta_ok   (xfer_ta_ok),
    .mode       (cfg_mode),
    .serr_en    (cfg_serr_en),
    .act        (act)
  );

  brab_resp #(.DW(DW)) u_rsp (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (xfer_valid),
    .in_abort    (xfer_mabort),
    .in_is_read  (xfer_is_read),
    .in_rdata    (xfer_rdata),
    .mode        (cfg_mode),
    .act         (act),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .rsp_discard (rsp_wr_discard),
    .rsp_ta      (rsp_tgt_abort),
    .serr_n      (serr_n)
  );

  p_serr_after_report_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_mabort && cfg_mode && !xfer_ta_ok && cfg_serr_en) |=> !serr_n);
  p_serr_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!serr_n && !(xfer_valid && xfer_mabort)) |=> serr_n);
endmodule

// File: tb/bridge_abort_resp_tb.sv
`timescale 1ns/1ps
module bridge_abort_resp_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_valid = 1'b0, xfer_mabort = 1'b0, xfer_is_read = 1'b0;
  logic        xfer_side = 1'b0, xfer_ta_ok = 1'b0;
  logic [31:0] xfer_rdata = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic        rsp_valid, rsp_wr_discard, rsp_tgt_abort, serr_n;
  logic [31:0] rsp_rdata;
  logic        cfg_mode, cfg_serr_en;
  logic [1:0]  sts_rma;

  always #2 clk = ~clk;

  bridge_abort_resp u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_mabort(xfer_mabort),
    .xfer_is_read(xfer_is_read), .xfer_side(xfer_side), .xfer_ta_ok(xfer_ta_ok),
    .xfer_rdata(xfer_rdata), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_wr_discard(rsp_wr_discard),
    .rsp_tgt_abort(rsp_tgt_abort), .serr_n(serr_n), .cfg_mode(cfg_mode),
    .cfg_serr_en(cfg_serr_en), .sts_rma(sts_rma)
  );

  typedef struct {
    logic [31:0] rdata;
    logic        discard;
    logic        ta;
    logic        serr;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0, bad = 0;
  bit   mon_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: registered outputs are compared at each falling edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected response", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(rsp_rdata == e.rdata, {e.tag, " rdata"}, rsp_rdata, e.rdata);
          chk(rsp_wr_discard == e.discard, {e.tag, " discard"}, {31'd0, rsp_wr_discard}, {31'd0, e.discard});
          chk(rsp_tgt_abort == e.ta, {e.tag, " target abort"}, {31'd0, rsp_tgt_abort}, {31'd0, e.ta});
          chk(serr_n == !e.serr, {e.tag, " serr_n"}, {31'd0, serr_n}, {31'd0, !e.serr});
        end
      end else begin
        if (!serr_n || rsp_tgt_abort || rsp_wr_discard)
          chk(1'b0, "R6 idle outputs", {29'd0, serr_n, rsp_tgt_abort, rsp_wr_discard}, 32'd4);
      end
    end
  end

  task automatic xfer(input bit side, input bit rd, input bit ab, input bit taok,
                      input logic [31:0] din, input logic [31:0] erd, input bit edis,
                      input bit eta, input bit eserr, input string tag);
    exp_t e;
    @(negedge clk);
    xfer_valid = 1'b1; xfer_side = side; xfer_is_read = rd;
    xfer_mabort = ab; xfer_ta_ok = taok; xfer_rdata = din;
    e.rdata = erd; e.discard = edis; e.ta = eta; e.serr = eserr; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    xfer_valid = 1'b0; xfer_mabort = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfg(input logic [3:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  localparam logic [31:0] ONES = 32'hFFFF_FFFF;
  bit done = 1'b0;

  initial begin
    #(4 * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_mode == 1'b0, "R1 mode reset", {31'd0, cfg_mode}, 32'd0);
    chk(cfg_serr_en == 1'b0, "R1 serr_en reset", {31'd0, cfg_serr_en}, 32'd0);
    chk(sts_rma == 2'b00, "R1 status reset", {30'd0, sts_rma}, 32'd0);
    chk(serr_n && !rsp_valid, "R1 outputs idle", {30'd0, serr_n, rsp_valid}, 32'd2);
    mon_on = 1'b1;

    xfer(0, 1, 0, 0, 32'h1234_5678, 32'h1234_5678, 0, 0, 0, "R2 plain read");
    xfer(1, 0, 0, 1, 32'hDEAD_BEEF, 32'h0, 0, 0, 0, "R2 plain write");
    xfer(0, 1, 1, 1, 32'h5555_0000, ONES, 0, 0, 0, "R3 quiet read");
    xfer(1, 0, 1, 0, 32'h0, 32'h0, 1, 0, 0, "R4 quiet write");
    chk(sts_rma == 2'b11, "R9 status both sides", {30'd0, sts_rma}, 32'd3);
    cfg(4'b0100);
    chk(sts_rma == 2'b10, "R9 clear side0", {30'd0, sts_rma}, 32'd2);
    cfg(4'b1000);
    chk(sts_rma == 2'b00, "R9 clear side1", {30'd0, sts_rma}, 32'd0);

    cfg(4'b0001);
    chk(cfg_mode && !cfg_serr_en, "R10 mode written", {30'd0, cfg_mode, cfg_serr_en}, 32'd2);
    xfer(0, 1, 1, 1, 32'h0, ONES, 0, 1, 0, "R5 report read primary");
    xfer(1, 1, 1, 1, 32'h0, ONES, 0, 1, 0, "R8 report read secondary");
    xfer(0, 0, 1, 1, 32'h0, 32'h0, 1, 1, 0, "R4 R5 report write");
    xfer(0, 1, 1, 0, 32'h0, ONES, 0, 0, 0, "R7 no serr enable");
    cfg(4'b0011);
    xfer(0, 1, 1, 0, 32'h0, ONES, 0, 0, 1, "R6 serr primary");
    xfer(1, 0, 1, 0, 32'h0, 32'h0, 1, 0, 1, "R8 serr secondary");
    xfer(1, 1, 0, 0, 32'hA5A5_5A5A, 32'hA5A5_5A5A, 0, 0, 0, "R2 plain in report mode");
    cfg(4'b1111);
    chk(sts_rma == 2'b00, "R9 cleared again", {30'd0, sts_rma}, 32'd0);

    // abort and clear on the same edge: set wins
    begin
      exp_t e;
      @(negedge clk);
      xfer_valid = 1'b1; xfer_side = 1'b0; xfer_is_read = 1'b1;
      xfer_mabort = 1'b1; xfer_ta_ok = 1'b1; xfer_rdata = '0;
      cfg_we = 1'b1; cfg_wdata = 4'b0100;   // also clears mode: R10 old mode used
      e.rdata = ONES; e.discard = 0; e.ta = 1; e.serr = 0; e.tag = "R10 old mode on write edge";
      exp_q.push_back(e);
      @(negedge clk);
      xfer_valid = 1'b0; xfer_mabort = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
      chk(sts_rma[0] == 1'b1, "R9 set beats clear", {31'd0, sts_rma[0]}, 32'd1);
      chk(!cfg_mode, "R10 new mode applied", {31'd0, cfg_mode}, 32'd0);
      @(negedge clk);
    end
    xfer(0, 1, 1, 1, 32'h0, ONES, 0, 0, 0, "R3 quiet after mode clear");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule